// File: doc/BRIEF.md
# Flash command sequence decoder

This block watches the bus cycles of a byte-wide parallel flash interface and recognizes multi-cycle command sequences written by a host. Each write cycle presents an address and a data word. A normal command starts with two fixed unlock writes. A third write selects the command. Program and erase sequences then continue for more cycles. A few commands are single writes, and unlock bypass mode gives shortened two-cycle sequences.

When a sequence completes, the decoder issues a one-cycle command pulse with a code, the captured address and the data byte. It also keeps three mode flags: autoselect, bypass and erase-suspended. A write that does not fit the current step drops the partial sequence. Read cycles pass through without effect. An external erase-busy input tells the decoder whether a sector erase is running, so that it can judge whether a suspend request is valid. The array, the embedded algorithms, strobe timing and status polling belong elsewhere.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, cmd_valid is 0 and autosel_mode, bypass_mode and suspend_mode are all 0.
- R2: Three writes (0xAA at 0xAAA, 0x55 at 0x555, 0x90 at 0xAAA) issue code 2 (autoselect) and set autosel_mode. Only data bits 7:0 and address bits 11:0 take part in matching.
- R3: Writes 0xAA@0xAAA, 0x55@0x555 and 0xA0@0xAAA, followed by any write, issue code 3 (program). cmd_addr carries that write's full address and cmd_data carries its data bits 7:0.
- R4: A write that does not match the expected address and data at any step of a sequence drops the sequence and issues no command. This also holds for a third-cycle byte that is not 0x90, 0xA0, 0x20 or 0x80.
- R5: Writes 0xAA@0xAAA, 0x55@0x555 and 0x20@0xAAA issue code 4 and set bypass_mode. While in bypass mode:
  - 0xA0 at any address, followed by any write, issues code 6 with that write's address and data.
  - 0x90 at any address, followed by 0x00 at any address, issues code 5 and clears bypass_mode.
  - Every other write issues nothing.
- R6: Writes 0xAA@0xAAA, 0x55@0x555, 0x80@0xAAA, 0xAA@0xAAA and 0x55@0x555, followed by a sixth write, select an erase. A sixth write of 0x10 at 0xAAA issues code 7 (chip erase). A sixth write of 0x30 at any address issues code 8 (sector erase), with cmd_addr set to that address.
- R7: Outside bypass mode, 0xF0 at any address issues code 1 (reset) and clears autosel_mode. suspend_mode is left unchanged, so a reset from autoselect entered while suspended returns to suspended reading.
- R8: A single write of 0xB0 issues code 9 and sets suspend_mode, but only while erase_busy is 1 and the decoder is not already suspended. A single write of 0x30 issues code 10 and clears suspend_mode, but only while suspended. Otherwise neither write has any effect.
- R9: A single write of 0x98 at address 0x0AA issues code 11 (query). It is accepted only outside bypass mode, and only when not suspended or when in autoselect mode.
- R10: Read cycles (cyc_vld=1, cyc_write=0) neither advance nor reset a partial sequence, and they issue no command.
- R11: cmd_valid is high for exactly one cycle per accepted command. cmd_code is 0 whenever cmd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_vld | input | 1 | A bus cycle is presented this clock |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| addr | input | AW | Byte address of the cycle |
| wdata | input | DW | Write data; only bits 7:0 are decoded |
| erase_busy | input | 1 | A sector erase is in progress |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_code | output | 4 | Command code (see R2 to R9), 0 when idle |
| cmd_addr | output | AW | Address of the completing write |
| cmd_data | output | 8 | Data bits 7:0 of the completing write |
| autosel_mode | output | 1 | Autoselect mode flag |
| bypass_mode | output | 1 | Unlock bypass mode flag |
| suspend_mode | output | 1 | Erase suspended flag |

## Verification
Every result is registered once. The command pulse, its address and data, and all three mode flags appear on the first clock edge after the write that completes or rejects a sequence, and the pulse is gone one edge later. The bench drives each cycle on a falling edge and samples the outputs on the next falling edge, which sits half a period after the edge that sampled the write. It then waits one more idle cycle where the pulse must already be low. Sweeps over all 256 data values in the first and third cycles compare the issued code against a value derived from the requirements.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW  = 21,
  parameter int DW  = 16,
  parameter int CMW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_vld,
  input  logic          cyc_write,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          erase_busy,
  output logic          cmd_valid,
  output logic [3:0]    cmd_code,
  output logic [AW-1:0] cmd_addr,
  output logic [7:0]    cmd_data,
  output logic          autosel_mode,
  output logic          bypass_mode,
  output logic          suspend_mode
);

  localparam logic [3:0] C_NONE = 4'd0, C_RESET = 4'd1, C_ASEL = 4'd2, C_PROG = 4'd3,
                         C_BENT = 4'd4, C_BEXT = 4'd5, C_BPRG = 4'd6, C_CHIP = 4'd7,
                         C_SECT = 4'd8, C_SUSP = 4'd9, C_RESM = 4'd10, C_QRY = 4'd11;
  localparam logic [CMW-1:0] A_HI = CMW'(12'hAAA);
  localparam logic [CMW-1:0] A_LO = CMW'(12'h555);
  localparam logic [CMW-1:0] A_QR = CMW'(12'h0AA);

  typedef enum logic [3:0] {
    S_IDLE, S_UL1, S_UL2, S_PRG, S_ER3, S_ER4, S_ER5, S_BPRG, S_BEXT
  } seq_t;

  seq_t st, st_n;
  logic [3:0] code_n;
  logic asel_n, byp_n, susp_n;

  wire        wr  = cyc_vld & cyc_write;
  wire [7:0]  cb  = wdata[7:0];
  wire [CMW-1:0] la = addr[CMW-1:0];
  wire        hi  = (la == A_HI);
  wire        lo  = (la == A_LO);
  logic unused_hi_data;
  assign unused_hi_data = ^wdata[DW-1:8];

  always_comb begin
    st_n   = st;
    code_n = C_NONE;
    asel_n = autosel_mode;
    byp_n  = bypass_mode;
    susp_n = suspend_mode;
    if (wr) begin
      case (st)
        S_IDLE: begin
          if (bypass_mode) begin
            if (cb == 8'hA0)      st_n = S_BPRG;
            else if (cb == 8'h90) st_n = S_BEXT;
          end else if (cb == 8'hF0) begin
            code_n = C_RESET;
            asel_n = 1'b0;
          end else if (cb == 8'hB0 && erase_busy && !suspend_mode) begin
            code_n = C_SUSP;
            susp_n = 1'b1;
          end else if (cb == 8'h30 && suspend_mode) begin
            code_n = C_RESM;
            susp_n = 1'b0;
          end else if (cb == 8'h98 && la == A_QR && (!suspend_mode || autosel_mode)) begin
            code_n = C_QRY;
          end else if (cb == 8'hAA && hi) begin
            st_n = S_UL1;
          end
        end
        S_UL1: st_n = (cb == 8'h55 && lo) ? S_UL2 : S_IDLE;
        S_UL2: begin
          st_n = S_IDLE;
          if (hi) begin
            case (cb)
              8'h90: begin code_n = C_ASEL; asel_n = 1'b1; end
              8'hA0: st_n = S_PRG;
              8'h20: begin code_n = C_BENT; byp_n = 1'b1; end
              8'h80: st_n = S_ER3;
              default: st_n = S_IDLE;
            endcase
          end
        end
        S_PRG: begin
          code_n = C_PROG;
          st_n   = S_IDLE;
        end
        S_ER3: st_n = (cb == 8'hAA && hi) ? S_ER4 : S_IDLE;
        S_ER4: st_n = (cb == 8'h55 && lo) ? S_ER5 : S_IDLE;
        S_ER5: begin
          st_n = S_IDLE;
          if (cb == 8'h10 && hi)  code_n = C_CHIP;
          else if (cb == 8'h30)   code_n = C_SECT;
        end
        S_BPRG: begin
          code_n = C_BPRG;
          st_n   = S_IDLE;
        end
        S_BEXT: begin
          st_n = S_IDLE;
          if (cb == 8'h00) begin
            code_n = C_BEXT;
            byp_n  = 1'b0;
          end
        end
        default: st_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cmd_valid    <= 1'b0;
      cmd_code     <= C_NONE;
      cmd_addr     <= '0;
      cmd_data     <= '0;
      autosel_mode <= 1'b0;
      bypass_mode  <= 1'b0;
      suspend_mode <= 1'b0;
    end else begin
      st           <= st_n;
      cmd_valid    <= (code_n != C_NONE);
      cmd_code     <= code_n;
      autosel_mode <= asel_n;
      bypass_mode  <= byp_n;
      suspend_mode <= susp_n;
      if (code_n != C_NONE) begin
        cmd_addr <= addr;
        cmd_data <= cb;
      end
    end
  end

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_vld && !cyc_write) |=> (st == $past(st)) && !cmd_valid);

  // R11
  pulse_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> (cmd_code == C_NONE));

  // R2
  asel_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_ASEL) |-> autosel_mode);

  // R5
  bypass_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_BPRG) |-> bypass_mode && $past(bypass_mode));

  // R7
  reset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_RESET) |-> !autosel_mode && (suspend_mode == $past(suspend_mode)));

  // R8
  suspend_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_SUSP) |-> $past(erase_busy) && !$past(suspend_mode) && suspend_mode);

  // R8
  resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_RESM) |-> $past(suspend_mode) && !suspend_mode);

  // R9
  query_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == C_QRY) |-> !bypass_mode && (!$past(suspend_mode) || $past(autosel_mode)));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_vld = 1'b0, cyc_write = 1'b0, erase_busy = 1'b0;
  logic [20:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        cmd_valid, autosel_mode, bypass_mode, suspend_mode;
  logic [3:0]  cmd_code;
  logic [20:0] cmd_addr;
  logic [7:0]  cmd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_vld(cyc_vld), .cyc_write(cyc_write),
    .addr(addr), .wdata(wdata), .erase_busy(erase_busy),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .autosel_mode(autosel_mode), .bypass_mode(bypass_mode), .suspend_mode(suspend_mode));

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic expc(input string req, input logic [3:0] code);
    chk(req, "cmd_valid", {31'd0, cmd_valid}, {31'd0, code != 4'd0});
    chk(req, "cmd_code", {28'd0, cmd_code}, {28'd0, code});
  endtask

  task automatic modes(input string req, input logic a, input logic b, input logic s);
    chk(req, "modes", {29'd0, autosel_mode, bypass_mode, suspend_mode}, {29'd0, a, b, s});
  endtask

  task automatic cyc(input logic w, input logic [20:0] a, input logic [15:0] d);
    cyc_vld = 1'b1; cyc_write = w; addr = a; wdata = d;
    @(negedge clk);
    cyc_vld = 1'b0; cyc_write = 1'b0;
  endtask

  task automatic wr(input logic [20:0] a, input logic [15:0] d);
    cyc(1'b1, a, d);
  endtask

  task automatic unlock();
    wr(21'h0AAA, 16'h00AA);
    wr(21'h0555, 16'h0055);
  endtask

  function automatic logic [3:0] third_exp(input logic [7:0] v);
    case (v)
      8'h90: return 4'd2;
      8'h20: return 4'd4;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] single_exp(input logic [7:0] v);
    if (v == 8'hF0) return 4'd1;
    if (v == 8'h98) return 4'd11;
    return 4'd0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expc("R1", 4'd0);
    modes("R1", 1'b0, 1'b0, 1'b0);

    // R2 with upper address and data bits set
    wr(21'h1F_FAAA, 16'hC3AA);
    wr(21'h15_5555, 16'h7E55);
    wr(21'h0A_3AAA, 16'hFF90);
    expc("R2", 4'd2);
    modes("R2", 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    expc("R11", 4'd0);
    wr(21'h12_3456, 16'h00F0);
    expc("R7", 4'd1);
    modes("R7", 1'b0, 1'b0, 1'b0);

    // R3 program
    unlock();
    wr(21'h0AAA, 16'h00A0);
    expc("R3", 4'd0);
    wr(21'h01_2345, 16'hFF5A);
    expc("R3", 4'd3);
    chk("R3", "cmd_addr", {11'd0, cmd_addr}, 32'h12345);
    chk("R3", "cmd_data", {24'd0, cmd_data}, 32'h5A);
    @(negedge clk);
    expc("R11", 4'd0);

    // R2 R4 R5 third-cycle sweep
    for (int v = 0; v < 256; v++) begin
      unlock();
      wr(21'(v << 12) | 21'h0AAA, 16'(v));
      expc(v == 8'h90 ? "R2" : (v == 8'h20 ? "R5" : "R4"), third_exp(8'(v)));
      if (v == 8'h90) begin
        wr(21'h0, 16'h00F0);
        expc("R7", 4'd1);
      end else if (v == 8'h20) begin
        modes("R5", 1'b0, 1'b1, 1'b0);
        wr(21'h0, 16'h0090);
        wr(21'h0, 16'h0000);
        expc("R5", 4'd5);
      end else if (v == 8'hA0) begin
        wr(21'h0777, 16'(v));
        expc("R3", 4'd3);
      end else if (v == 8'h80) begin
        wr(21'h0, 16'h0000);
        expc("R4", 4'd0);
      end
      modes("R4", 1'b0, 1'b0, 1'b0);
    end

    // R7 R8 R9 single-cycle sweep at 0x0AA, not busy, not suspended
    for (int v = 0; v < 256; v++) begin
      wr(21'h0_00AA, 16'(v));
      expc(v == 8'h98 ? "R9" : (v == 8'hF0 ? "R7" : "R8"), single_exp(8'(v)));
      modes("R8", 1'b0, 1'b0, 1'b0);
    end

    // R4 aborts
    wr(21'h0AAA, 16'h00AA);
    wr(21'h0554, 16'h0055);
    wr(21'h0AAA, 16'h0090);
    expc("R4", 4'd0);
    modes("R4", 1'b0, 1'b0, 1'b0);
    unlock();
    wr(21'h0AAA, 16'h0080);
    wr(21'h0AAA, 16'h00AA);
    wr(21'h0556, 16'h0055);
    wr(21'h0AAA, 16'h0010);
    expc("R4", 4'd0);

    // R10 reads inside a sequence
    wr(21'h0AAA, 16'h00AA);
    cyc(1'b0, 21'h0555, 16'h0055);
    expc("R10", 4'd0);
    cyc(1'b0, 21'h0AAA, 16'h00F0);
    wr(21'h0555, 16'h0055);
    cyc(1'b0, 21'h0AAA, 16'h0090);
    expc("R10", 4'd0);
    wr(21'h0AAA, 16'h0090);
    expc("R10", 4'd2);
    wr(21'h0, 16'h00F0);
    expc("R7", 4'd1);

    // R6 chip and sector erase
    unlock();
    wr(21'h0AAA, 16'h0080);
    unlock();
    wr(21'h0AAA, 16'h0010);
    expc("R6", 4'd7);
    unlock();
    wr(21'h0AAA, 16'h0080);
    unlock();
    wr(21'h1B_3123, 16'h0030);
    expc("R6", 4'd8);
    chk("R6", "cmd_addr", {11'd0, cmd_addr}, 32'h1B3123);

    // R8 R9 R7 suspend, autoselect from suspend, resume
    erase_busy = 1'b1;
    wr(21'h10_0000, 16'h00B0);
    expc("R8", 4'd9);
    modes("R8", 1'b0, 1'b0, 1'b1);
    chk("R8", "cmd_addr", {11'd0, cmd_addr}, 32'h100000);
    wr(21'h10_0000, 16'h00B0);
    expc("R8", 4'd0);
    wr(21'h0_00AA, 16'h0098);
    expc("R9", 4'd0);
    unlock();
    wr(21'h0AAA, 16'h0090);
    expc("R2", 4'd2);
    modes("R2", 1'b1, 1'b0, 1'b1);
    wr(21'h0_00AA, 16'h0098);
    expc("R9", 4'd11);
    wr(21'h0, 16'h00F0);
    expc("R7", 4'd1);
    modes("R7", 1'b0, 1'b0, 1'b1);
    wr(21'h10_0000, 16'h0030);
    expc("R8", 4'd10);
    modes("R8", 1'b0, 1'b0, 1'b0);
    erase_busy = 1'b0;

    // R5 bypass mode behaviour
    unlock();
    wr(21'h0AAA, 16'h0020);
    expc("R5", 4'd4);
    wr(21'h1_2000, 16'h00A0);
    expc("R5", 4'd0);
    wr(21'h00_4321, 16'h77C3);
    expc("R5", 4'd6);
    chk("R5", "cmd_addr", {11'd0, cmd_addr}, 32'h4321);
    chk("R5", "cmd_data", {24'd0, cmd_data}, 32'hC3);
    wr(21'h0AAA, 16'h00F0);
    expc("R5", 4'd0);
    modes("R5", 1'b0, 1'b1, 1'b0);
    wr(21'h0_00AA, 16'h0098);
    expc("R9", 4'd0);
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0001);
    expc("R5", 4'd0);
    modes("R5", 1'b0, 1'b1, 1'b0);
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0000);
    expc("R5", 4'd5);
    modes("R5", 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    expc("R11", 4'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule